// File: doc/BRIEF.md
# Addressed SPI Register Front End for an 8-bit I/O Expander

This block is the serial slave side of an 8-bit port expander. A host talks to it over a four-wire SPI link in mode 0: clock idle low, data sampled on the rising clock edge and changed on the falling edge. The SPI pins are oversampled on the system clock. Every frame starts with a control byte. Its upper nibble is a fixed device prefix and its lower nibble holds a 3-bit device address and a read/write flag. A register index byte follows, and after it any number of data bytes go in or come out.

Because the control byte carries an address, up to eight expanders can share one chip select. A configuration bit decides whether that address is compared with the static strap pins. A second configuration bit decides whether the register index advances after each data byte. The block holds the direction, polarity, interrupt-enable, compare-value, interrupt-control, configuration, pull-up and output-latch registers and drives them out to the pin logic. Flag, capture and port values come in from the pin logic and can be read back.

Top module: `spi_gpio_regfile`

## Requirements
- R1: After reset the direction output is 0xFF. The polarity, interrupt-enable, compare-value, interrupt-control, configuration, pull-up and latch outputs are all 0x00, and the MISO enable is low.
- R2: The control byte is {4'b0100, addr[2:0], rw}, sent MSB first; rw=0 selects a write. In a write frame the second byte is the register index. The first data byte lands in that register when its eighth bit is sampled. Index map: 0 direction, 1 polarity, 2 interrupt enable, 3 compare value, 4 interrupt control, 5 configuration, 6 pull-up, 10 output latch.
- R3: With rw=1, data is shifted out on MISO, MSB first, starting at the SCK falling edge that follows the index byte. The MISO enable is high while that data is driven.
- R4: While configuration bit 5 is 0, the index increments after every data byte, for both reads and writes. After index 10 it wraps to 0.
- R5: While configuration bit 5 is 1, the index stays fixed, so every data byte of a frame reaches the same register.
- R6: While configuration bit 3 is 0, the address bits of the control byte are ignored and the block answers any address.
- R7: A control byte whose upper nibble is not 0100 makes the block ignore the rest of the frame. No register changes and MISO stays disabled until chip select rises.
- R8: While configuration bit 3 is 1, a control byte whose address differs from the strap pins is ignored in the same way as in R7.
- R9: Index 7 reads the interrupt flag input, index 8 the capture input and index 9 the port input. Indexes 11 to 255 read as 0x00.
- R10: A write to index 9 loads the output latch. Writes to indexes 7, 8 and 11 to 255 change no output.
- R11: A byte cut short by chip select rising is discarded. Bytes completed earlier in the frame stay written.
- R12: The MISO enable is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hw_addr | input | 3 | Static device address straps |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock |
| spi_mosi | input | 1 | SPI data in |
| spi_miso | output | 1 | SPI data out |
| spi_miso_oe | output | 1 | Output enable for MISO |
| port_in | input | 8 | Pin levels from the pad logic |
| int_flag | input | 8 | Interrupt flag value from pin logic |
| int_capture | input | 8 | Captured pin value from pin logic |
| dir_o | output | 8 | Direction register (1 = input) |
| pol_o | output | 8 | Input polarity register |
| inten_o | output | 8 | Interrupt enable register |
| defval_o | output | 8 | Compare value register |
| intctl_o | output | 8 | Interrupt control register |
| cfg_o | output | 8 | Configuration register |
| pullup_o | output | 8 | Pull-up register |
| olat_o | output | 8 | Output latch register |

## Verification
The assertions assume SCK, MOSI and chip select are slow compared with the system clock. They expect each SCK half period to be longer than the synchronizer and edge-detect delay, chip select to move only while SCK is low, and the strap pins to stay static. The stimulus keeps within this. It holds every SCK level for six system clocks, changes MOSI together with the SCK falling edge, and waits half an SCK period on each side of a chip-select edge. A partial byte is produced only by raising chip select after a falling SCK edge.

// File: rtl/spi_gpio_regfile.sv
module spi_gpio_regfile #(
  parameter logic [3:0] PREFIX      = 4'b0100,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] LAST_REG    = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hw_addr,
  input  logic       spi_csn,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic [7:0] port_in,
  input  logic [7:0] int_flag,
  input  logic [7:0] int_capture,
  output logic [7:0] dir_o,
  output logic [7:0] pol_o,
  output logic [7:0] inten_o,
  output logic [7:0] defval_o,
  output logic [7:0] intctl_o,
  output logic [7:0] cfg_o,
  output logic [7:0] pullup_o,
  output logic [7:0] olat_o
);
  localparam int SEQ_OFF_BIT = 5;
  localparam int HW_EN_BIT   = 3;
  localparam logic [2:0] S_CTRL = 3'd0, S_ADDR = 3'd1, S_WR = 3'd2,
                         S_RD = 3'd3, S_SKIP = 3'd4;

  logic [SYNC_STAGES-1:0] csn_sy, sck_sy, mosi_sy;
  logic sck_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      csn_sy  <= '1;
      sck_sy  <= '0;
      mosi_sy <= '0;
      sck_d   <= 1'b0;
    end else begin
      csn_sy  <= {csn_sy[SYNC_STAGES-2:0], spi_csn};
      sck_sy  <= {sck_sy[SYNC_STAGES-2:0], spi_sck};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], spi_mosi};
      sck_d   <= sck_sy[SYNC_STAGES-1];
    end

  wire cs_hi   = csn_sy[SYNC_STAGES-1];
  wire sck_now = sck_sy[SYNC_STAGES-1];
  wire rise    = !cs_hi && sck_now && !sck_d;
  wire fall    = !cs_hi && !sck_now && sck_d;

  logic [2:0] state, bitcnt;
  logic [6:0] sh;
  logic [7:0] ptr, tx, rdata;
  logic       rd_q;
  wire  [7:0] rx_byte   = {sh, mosi_sy[SYNC_STAGES-1]};
  wire        byte_done = rise && (bitcnt == 3'd7);
  wire        addr_ok   = !cfg_o[HW_EN_BIT] || (rx_byte[3:1] == hw_addr);
  wire [7:0]  next_ptr  = cfg_o[SEQ_OFF_BIT] ? ptr :
                          (ptr >= LAST_REG) ? 8'h00 : ptr + 8'd1;
  wire        wr_en     = byte_done && (state == S_WR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= S_CTRL;
      bitcnt      <= '0;
      sh          <= '0;
      ptr         <= '0;
      rd_q        <= 1'b0;
      tx          <= '0;
      spi_miso    <= 1'b0;
      spi_miso_oe <= 1'b0;
    end else if (cs_hi) begin
      state       <= S_CTRL;
      bitcnt      <= '0;
      spi_miso_oe <= 1'b0;
    end else begin
      if (rise) begin
        sh     <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
      end
      if (byte_done)
        case (state)
          S_CTRL: begin
            rd_q  <= rx_byte[0];
            state <= (rx_byte[7:4] == PREFIX && addr_ok) ? S_ADDR : S_SKIP;
          end
          S_ADDR: begin
            ptr   <= rx_byte;
            state <= rd_q ? S_RD : S_WR;
          end
          S_WR, S_RD: ptr <= next_ptr;
          default: ;
        endcase
      if (fall && state == S_RD) begin
        spi_miso_oe <= 1'b1;
        if (bitcnt == 3'd0) begin
          spi_miso <= rdata[7];
          tx       <= {rdata[6:0], 1'b0};
        end else begin
          spi_miso <= tx[7];
          tx       <= {tx[6:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_o    <= 8'hFF;
      pol_o    <= '0;
      inten_o  <= '0;
      defval_o <= '0;
      intctl_o <= '0;
      cfg_o    <= '0;
      pullup_o <= '0;
      olat_o   <= '0;
    end else if (wr_en) begin
      case (ptr)
        8'h00: dir_o    <= rx_byte;
        8'h01: pol_o    <= rx_byte;
        8'h02: inten_o  <= rx_byte;
        8'h03: defval_o <= rx_byte;
        8'h04: intctl_o <= rx_byte;
        8'h05: cfg_o    <= rx_byte;
        8'h06: pullup_o <= rx_byte;
        8'h09, 8'h0A: olat_o <= rx_byte;
        default: ;
      endcase
    end

  always_comb
    case (ptr)
      8'h00: rdata = dir_o;
      8'h01: rdata = pol_o;
      8'h02: rdata = inten_o;
      8'h03: rdata = defval_o;
      8'h04: rdata = intctl_o;
      8'h05: rdata = cfg_o;
      8'h06: rdata = pullup_o;
      8'h07: rdata = int_flag;
      8'h08: rdata = int_capture;
      8'h09: rdata = port_in;
      8'h0A: rdata = olat_o;
      default: rdata = 8'h00;
    endcase
endmodule

module spi_gpio_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       byte_done,
  input logic [7:0] ptr,
  input logic       cs_hi,
  input logic       spi_miso_oe,
  input logic [7:0] dir_o,
  input logic [7:0] olat_o,
  input logic [7:0] cfg_o
);
  localparam logic [2:0] S_WR = 3'd2, S_SKIP = 3'd4;

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_o == 8'hFF && olat_o == 8'h00 && cfg_o == 8'h00)); // R1
  AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_hi) |-> !spi_miso_oe); // R12
  AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |=> ($stable(dir_o) && $stable(olat_o) && $stable(cfg_o))); // R7
  AST_DIR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_o != $past(dir_o)) |-> $past(state == S_WR)); // R2
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == S_WR && byte_done && cfg_o[5]) |-> (ptr == $past(ptr))); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == S_WR && byte_done && !cfg_o[5] && ptr == 8'h0A) |-> (ptr == 8'h00)); // R4
endmodule

bind spi_gpio_regfile spi_gpio_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .byte_done(byte_done), .ptr(ptr),
  .cs_hi(cs_hi), .spi_miso_oe(spi_miso_oe), .dir_o(dir_o), .olat_o(olat_o),
  .cfg_o(cfg_o)
);

// File: tb/test_spi_gpio_regfile.sv
module test_spi_gpio_regfile;
  localparam int HALF = 6;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] P_IN = 8'hC3, P_FLAG = 8'h24, P_CAP = 8'h81;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [7:0] dir_o, pol_o, inten_o, defval_o, intctl_o, cfg_o, pullup_o, olat_o;

  always #4 clk = ~clk;

  spi_gpio_regfile i_spi_gpio_regfile (
    .clk(clk), .rst_n(rst_n), .hw_addr(PINS),
    .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .port_in(P_IN), .int_flag(P_FLAG), .int_capture(P_CAP),
    .dir_o(dir_o), .pol_o(pol_o), .inten_o(inten_o), .defval_o(defval_o),
    .intctl_o(intctl_o), .cfg_o(cfg_o), .pullup_o(pullup_o), .olat_o(olat_o)
  );

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [7:0] mdl [0:10];
  logic [7:0] ftx [0:15];
  logic [7:0] frx [0:15];
  logic       foe [0:15];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk({req, " dir"}, dir_o, mdl[0]);
    chk({req, " pol"}, pol_o, mdl[1]);
    chk({req, " inten"}, inten_o, mdl[2]);
    chk({req, " defval"}, defval_o, mdl[3]);
    chk({req, " intctl"}, intctl_o, mdl[4]);
    chk({req, " cfg"}, cfg_o, mdl[5]);
    chk({req, " pullup"}, pullup_o, mdl[6]);
    chk({req, " olat"}, olat_o, mdl[10]);
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a <= 8'h06 || a == 8'h0A) return mdl[a[3:0]];
    if (a == 8'h07) return P_FLAG;
    if (a == 8'h08) return P_CAP;
    if (a == 8'h09) return P_IN;
    return 8'h00;
  endfunction

  task automatic bit_x(input logic b, output logic r, output logic o);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    r = spi_miso;
    o = spi_miso_oe;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic run_frame(input int n, input int last_bits);
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int nb;
      logic [7:0] r;
      logic o, rb, ob;
      nb = (i == n - 1) ? last_bits : 8;
      r = '0;
      o = 1'b0;
      for (int b = 7; b > 7 - nb; b--) begin
        bit_x(ftx[i][b], rb, ob);
        r[b] = rb;
        o = o | ob;
      end
      frx[i] = r;
      foe[i] = o;
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] r, input logic [7:0] d);
    ftx[0] = {4'b0100, a, 1'b0};
    ftx[1] = r;
    ftx[2] = d;
    run_frame(3, 8);
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [7:0] r,
                        output logic [7:0] d, output logic o);
    ftx[0] = {4'b0100, a, 1'b1};
    ftx[1] = r;
    ftx[2] = 8'h00;
    run_frame(3, 8);
    d = frx[2];
    o = foe[2];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic o;
    for (int k = 0; k <= 10; k++) mdl[k] = 8'h00;
    mdl[0] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_outs("R1");
    chk("R1 oe", {7'd0, spi_miso_oe}, 8'h00);

    // R2, R6: per-register writes with varying device address while hardware addressing is off
    for (int k = 0; k <= 10; k++) begin
      if (k == 5 || (k >= 7 && k <= 9)) continue;
      mdl[k] = (8'h11 * k[7:0]) ^ 8'h96;
      wr_reg(k[2:0], k[7:0], mdl[k]);
      chk_outs("R2/R6");
    end
    // R3, R9: read every index 0..15
    for (int k = 0; k < 16; k++) begin
      rd_reg(3'(k + 3), k[7:0], d, o);
      chk("R3/R9 read", d, exp_rd(k[7:0]));
      chk("R3 oe", {7'd0, o}, 8'h01);
    end
    // R10: ignored writes, then write through index 9
    foreach (ftx[i]) ftx[i] = 8'h00;
    for (int k = 7; k < 16; k++) begin
      if (k == 9 || k == 10) continue;
      wr_reg(3'd0, k[7:0], 8'hEE);
      chk_outs("R10 ignored");
    end
    wr_reg(3'd1, 8'h09, 8'h5C);
    mdl[10] = 8'h5C;
    chk_outs("R10 index9");

    // R4: burst write crossing the wrap
    ftx[0] = 8'h40; ftx[1] = 8'h08;
    ftx[2] = 8'hA0; ftx[3] = 8'hA1; ftx[4] = 8'hA2; ftx[5] = 8'hA3; ftx[6] = 8'hA4;
    run_frame(7, 8);
    mdl[10] = 8'hA2; mdl[0] = 8'hA3; mdl[1] = 8'hA4;
    chk_outs("R4 burst write");
    ftx[0] = 8'h41; ftx[1] = 8'h00;
    for (int i = 2; i < 14; i++) ftx[i] = 8'h00;
    run_frame(14, 8);
    for (int i = 0; i < 12; i++) chk("R4 burst read", frx[i + 2], exp_rd(8'(i % 11)));

    // R5: sequential addressing off
    wr_reg(3'd2, 8'h05, 8'h20);
    mdl[5] = 8'h20;
    ftx[0] = 8'h40; ftx[1] = 8'h06; ftx[2] = 8'h11; ftx[3] = 8'h22; ftx[4] = 8'h33;
    run_frame(5, 8);
    mdl[6] = 8'h33;
    chk_outs("R5 hold write");
    ftx[0] = 8'h41; ftx[1] = 8'h02; ftx[2] = 8'h00; ftx[3] = 8'h00; ftx[4] = 8'h00;
    run_frame(5, 8);
    for (int i = 2; i < 5; i++) chk("R5 hold read", frx[i], mdl[2]);

    // R8: hardware addressing on, sweep all device addresses
    wr_reg(3'd6, 8'h05, 8'h28);
    mdl[5] = 8'h28;
    chk_outs("R6 cfg");
    for (int a = 0; a < 8; a++) begin
      wr_reg(a[2:0], 8'h0A, 8'h30 + a[7:0]);
      if (a[2:0] == PINS) mdl[10] = 8'h30 + a[7:0];
      chk("R8 write olat", olat_o, mdl[10]);
      rd_reg(a[2:0], 8'h0A, d, o);
      chk("R8 read oe", {7'd0, o}, (a[2:0] == PINS) ? 8'h01 : 8'h00);
      if (a[2:0] == PINS) chk("R8 read data", d, mdl[10]);
    end
    wr_reg(PINS, 8'h05, 8'h08);
    mdl[5] = 8'h08;
    chk_outs("R8 cfg");

    // R7: every wrong prefix, write and read
    for (int p = 0; p < 16; p++) begin
      if (p == 4) continue;
      ftx[0] = {p[3:0], PINS, 1'b0}; ftx[1] = 8'h0A; ftx[2] = ~mdl[10];
      run_frame(3, 8);
      chk("R7 write ignored", olat_o, mdl[10]);
      ftx[0] = {p[3:0], PINS, 1'b1}; ftx[1] = 8'h0A; ftx[2] = 8'h00;
      run_frame(3, 8);
      chk("R7 oe", {7'd0, foe[1] | foe[2]}, 8'h00);
    end
    chk_outs("R7 all");

    // R11: partial bytes
    ftx[0] = {4'b0100, PINS, 1'b0}; ftx[1] = 8'h0A; ftx[2] = 8'hFF;
    run_frame(3, 5);
    chk_outs("R11 partial data");
    ftx[0] = {4'b0100, PINS, 1'b0}; ftx[1] = 8'h0A; ftx[2] = 8'h6D; ftx[3] = 8'h00;
    run_frame(4, 7);
    mdl[10] = 8'h6D;
    chk_outs("R11 kept bytes");

    chk("R12 oe idle", {7'd0, spi_miso_oe}, 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule